// File: doc/BRIEF.md
# Fetch Address Sequencer with Return Stack

This block produces the instruction fetch address for a small processor core. A 21-bit program counter advances by one two-byte instruction word per step, or loads a branch target, or jumps to a fixed vector when an interrupt is taken. Subroutine calls and interrupt entries save a return address on a private hardware stack of 31 entries. This stack cannot be reached through the program or data address maps. A return request restores the most recently saved address.

Each cycle the core presents at most a handful of request lines together with a target address. The sequencer resolves them by a fixed priority and updates the counter on the next clock edge. Two sticky status outputs report a push that found the stack full and a pop that found it empty. Only a reset clears them.

Top module: `fetch_pc_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) overrides every other input. After it, pc_o is 0x000000, the stack holds no entries and both status flags are low.
- R2: With only adv_i high, pc_o increases by 2 at the next edge, modulo 2^21 (0x1FFFFE is followed by 0x000000).
- R3: With only jump_i high, pc_o loads target_i and the stack is unchanged. With no request high, pc_o holds its value.
- R4: call_i loads target_i into pc_o and pushes pc_o + 2, the address of the following instruction.
- R5: ret_i loads pc_o from the most recently pushed entry and removes it. Entries return in last-in, first-out order for up to 31 nested pushes.
- R6: irq_hi_i loads 0x000008 and pushes the current pc_o. It takes priority over irq_lo_i, ret_i, call_i, jump_i and adv_i in the same cycle, and those requests are ignored.
- R7: irq_lo_i, when irq_hi_i is low, loads 0x000018 and pushes the current pc_o. It takes priority over ret_i, call_i, jump_i and adv_i, and those requests are ignored.
- R8: When call_i and ret_i are both high with no interrupt, the return is performed and the call is ignored: nothing is pushed and target_i is not loaded.
- R9: A push while 31 entries are held sets ovf_o. ovf_o then stays high until reset. The held entries are not altered, and pc_o still loads the target or vector.
- R10: A pop while the stack is empty sets unf_o. unf_o then stays high until reset, and pc_o loads 0x000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Step to the next sequential instruction |
| jump_i | input | 1 | Load target_i without saving a return address |
| call_i | input | 1 | Save the return address and load target_i |
| ret_i | input | 1 | Restore the most recent return address |
| irq_hi_i | input | 1 | Take the high-priority interrupt |
| irq_lo_i | input | 1 | Take the low-priority interrupt |
| target_i | input | 21 | Branch or call destination |
| pc_o | output | 21 | Current fetch address |
| ovf_o | output | 1 | Sticky stack overflow status |
| unf_o | output | 1 | Sticky stack underflow status |

## Verification
A vector table runs single requests and then conflicting combinations: interrupt plus call, both interrupts together, high interrupt plus return, and call plus return. Each combination has a different expected next address and a different stack effect, so a wrong priority order shows up either at once or on a later return. Nested calls mixed with interrupt entries, and the returns that unwind them, separate the call's pc+2 return address from the interrupt's current-pc one and also check LIFO ordering. Directed runs fill the stack to exactly 31 entries, push once more, and unwind all of it. This shows that the overflow left every entry in place, and that the pop after the last entry raises underflow and returns zero.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int unsigned PC_WIDTH     = 21;
    localparam int unsigned RSTACK_DEPTH = 31;
    localparam int unsigned WORD_STEP    = 2;

    localparam logic [PC_WIDTH-1:0] VEC_RESET = 21'h000000;
    localparam logic [PC_WIDTH-1:0] VEC_HIGH  = 21'h000008;
    localparam logic [PC_WIDTH-1:0] VEC_LOW   = 21'h000018;

    typedef enum logic [2:0] {
        NXT_HOLD,
        NXT_SEQ,
        NXT_TARGET,
        NXT_VEC_HI,
        NXT_VEC_LO,
        NXT_POP
    } next_sel_e;

    typedef struct packed {
        next_sel_e sel;
        logic      push;
        logic      pop;
        logic      push_next;
    } flow_ctl_t;

    typedef struct packed {
        logic adv;
        logic jump;
        logic call;
        logic ret;
        logic irq_hi;
        logic irq_lo;
    } flow_req_t;

    function automatic flow_ctl_t resolve_flow(input flow_req_t r);
        flow_ctl_t c;
        c = '{sel: NXT_HOLD, push: 1'b0, pop: 1'b0, push_next: 1'b0};
        if (r.irq_hi) begin
            c.sel  = NXT_VEC_HI;
            c.push = 1'b1;
        end else if (r.irq_lo) begin
            c.sel  = NXT_VEC_LO;
            c.push = 1'b1;
        end else if (r.ret) begin
            c.sel = NXT_POP;
            c.pop = 1'b1;
        end else if (r.call) begin
            c.sel       = NXT_TARGET;
            c.push      = 1'b1;
            c.push_next = 1'b1;
        end else if (r.jump) begin
            c.sel = NXT_TARGET;
        end else if (r.adv) begin
            c.sel = NXT_SEQ;
        end
        return c;
    endfunction

endpackage

// File: rtl/pcu_arbiter.sv
module pcu_arbiter
    import pcu_pkg::*;
(
    input  flow_req_t req_i,
    output flow_ctl_t ctl_o
);
    always_comb begin
        ctl_o = resolve_flow(req_i);
    end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
    parameter int unsigned W     = 21,
    parameter int unsigned DEPTH = 31
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_en,
    input  logic [W-1:0] push_val,
    input  logic         pop_en,
    output logic [W-1:0] top_val,
    output logic         ovf_o,
    output logic         unf_o
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     slot_q [DEPTH];
    logic             full, empty, do_push, do_pop;
    logic [IDX_W-1:0] top_idx;
    logic             ovf_q, unf_q;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push_en && !full;
    assign do_pop  = pop_en && !empty;
    assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
    assign top_val = empty ? '0 : slot_q[top_idx];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (cnt_q == CNT_W'(i))) begin
                slot_q[i] <= push_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (do_push) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (do_pop) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (push_en && full) begin
                ovf_q <= 1'b1;
            end
            if (pop_en && empty) begin
                unf_q <= 1'b1;
            end
        end
    end

    assign ovf_o = ovf_q;
    assign unf_o = unf_q;
endmodule

// File: rtl/pcu_next_pc.sv
module pcu_next_pc
    import pcu_pkg::*;
#(
    parameter int unsigned          PC_W  = 21,
    parameter int unsigned          STEP  = 2,
    parameter logic [PC_W-1:0]      HI_AT = 21'h000008,
    parameter logic [PC_W-1:0]      LO_AT = 21'h000018
) (
    input  next_sel_e        sel_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic [PC_W-1:0]  pop_val_i,
    output logic [PC_W-1:0]  seq_o,
    output logic [PC_W-1:0]  next_o
);
    assign seq_o = pc_i + PC_W'(STEP);

    always_comb begin
        unique case (sel_i)
            NXT_SEQ:    next_o = seq_o;
            NXT_TARGET: next_o = target_i;
            NXT_VEC_HI: next_o = HI_AT;
            NXT_VEC_LO: next_o = LO_AT;
            NXT_POP:    next_o = pop_val_i;
            default:    next_o = pc_i;
        endcase
    end
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import pcu_pkg::*;
#(
    parameter int unsigned     PC_W     = PC_WIDTH,
    parameter int unsigned     STK_SIZE = RSTACK_DEPTH,
    parameter int unsigned     STEP     = WORD_STEP,
    parameter logic [PC_W-1:0] RST_AT   = VEC_RESET,
    parameter logic [PC_W-1:0] HI_AT    = VEC_HIGH,
    parameter logic [PC_W-1:0] LO_AT    = VEC_LOW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv_i,
    input  logic            jump_i,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            irq_hi_i,
    input  logic            irq_lo_i,
    input  logic [PC_W-1:0] target_i,
    output logic [PC_W-1:0] pc_o,
    output logic            ovf_o,
    output logic            unf_o
);
    flow_req_t       req;
    flow_ctl_t       ctl;
    logic [PC_W-1:0] pc_q, pc_d, seq_pc, pop_val, push_val;

    assign req = '{adv: adv_i, jump: jump_i, call: call_i, ret: ret_i,
                   irq_hi: irq_hi_i, irq_lo: irq_lo_i};

    pcu_arbiter u_arb (
        .req_i (req),
        .ctl_o (ctl)
    );

    pcu_next_pc #(
        .PC_W  (PC_W),
        .STEP  (STEP),
        .HI_AT (HI_AT),
        .LO_AT (LO_AT)
    ) u_next (
        .sel_i     (ctl.sel),
        .pc_i      (pc_q),
        .target_i  (target_i),
        .pop_val_i (pop_val),
        .seq_o     (seq_pc),
        .next_o    (pc_d)
    );

    assign push_val = ctl.push_next ? seq_pc : pc_q;

    pcu_ret_stack #(
        .W     (PC_W),
        .DEPTH (STK_SIZE)
    ) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push_en  (ctl.push),
        .push_val (push_val),
        .pop_en   (ctl.pop),
        .top_val  (pop_val),
        .ovf_o    (ovf_o),
        .unf_o    (unf_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RST_AT;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int unsigned PC_W = 21,
    parameter int unsigned STEP = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            adv_i,
    input logic            jump_i,
    input logic            call_i,
    input logic            ret_i,
    input logic            irq_hi_i,
    input logic            irq_lo_i,
    input logic [PC_W-1:0] target_i,
    input logic [PC_W-1:0] pc_o,
    input logic            ovf_o,
    input logic            unf_o
);
    logic any_req;
    assign any_req = adv_i | jump_i | call_i | ret_i | irq_hi_i | irq_lo_i;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pc_o == '0) && !ovf_o && !unf_o);

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !jump_i && !call_i && !ret_i && !irq_hi_i && !irq_lo_i)
        |=> pc_o == $past(pc_o) + PC_W'(STEP));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !any_req |=> $stable(pc_o));

    assert_jump_load_R3: assert property (@(posedge clk) disable iff (rst)
        (jump_i && !call_i && !ret_i && !irq_hi_i && !irq_lo_i)
        |=> pc_o == $past(target_i));

    assert_hi_vector_R6: assert property (@(posedge clk) disable iff (rst)
        irq_hi_i |=> pc_o == PC_W'(8));

    assert_lo_vector_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_lo_i && !irq_hi_i) |=> pc_o == PC_W'(24));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

    assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        unf_o |=> unf_o);

    assert_unf_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (!unf_o && !irq_hi_i && !irq_lo_i && ret_i) ##1 unf_o |-> pc_o == '0);
endmodule

bind fetch_pc_unit pcu_checker #(.PC_W(PC_W), .STEP(STEP)) u_pcu_checker (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (adv_i),
    .jump_i   (jump_i),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .irq_hi_i (irq_hi_i),
    .irq_lo_i (irq_lo_i),
    .target_i (target_i),
    .pc_o     (pc_o),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
);

// File: tb/fetch_pc_unit_bench.sv
module fetch_pc_unit_bench;
    localparam int W = 21;

    // request bit positions: {hi, lo, ret, call, jump, adv}
    localparam logic [5:0] Q_NONE = 6'b000000;
    localparam logic [5:0] Q_ADV  = 6'b000001;
    localparam logic [5:0] Q_JMP  = 6'b000010;
    localparam logic [5:0] Q_CALL = 6'b000100;
    localparam logic [5:0] Q_RET  = 6'b001000;
    localparam logic [5:0] Q_LO   = 6'b010000;
    localparam logic [5:0] Q_HI   = 6'b100000;

    typedef struct packed {
        logic [5:0]   req;
        logic [W-1:0] tgt;
        logic [W-1:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{Q_ADV,          21'h0,      21'h000002},
        '{Q_ADV,          21'h0,      21'h000004},
        '{Q_JMP,          21'h000100, 21'h000100},
        '{Q_CALL,         21'h002000, 21'h002000},
        '{Q_ADV,          21'h0,      21'h002002},
        '{Q_CALL,         21'h003000, 21'h003000},
        '{Q_LO | Q_CALL,  21'h007000, 21'h000018},
        '{Q_HI | Q_LO,    21'h0,      21'h000008},
        '{Q_RET,          21'h0,      21'h000018},
        '{Q_HI | Q_RET,   21'h0,      21'h000008},
        '{Q_RET,          21'h0,      21'h000018},
        '{Q_RET,          21'h0,      21'h003000},
        '{Q_RET,          21'h0,      21'h002004},
        '{Q_CALL | Q_RET, 21'h005000, 21'h000102},
        '{Q_NONE,         21'h0,      21'h000102},
        '{Q_JMP,          21'h1FFFFE, 21'h1FFFFE},
        '{Q_ADV,          21'h0,      21'h000000},
        '{Q_ADV,          21'h0,      21'h000002}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         adv_i = 1'b0, jump_i = 1'b0, call_i = 1'b0, ret_i = 1'b0;
    logic         irq_hi_i = 1'b0, irq_lo_i = 1'b0;
    logic [W-1:0] target_i = '0;
    logic [W-1:0] pc_o;
    logic         ovf_o, unf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fetch_pc_unit u_fetch_pc_unit (
        .clk(clk), .rst(rst), .adv_i(adv_i), .jump_i(jump_i), .call_i(call_i),
        .ret_i(ret_i), .irq_hi_i(irq_hi_i), .irq_lo_i(irq_lo_i),
        .target_i(target_i), .pc_o(pc_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic drive(input logic [5:0] q, input logic [W-1:0] t);
        {irq_hi_i, irq_lo_i, ret_i, call_i, jump_i, adv_i} = q;
        target_i = t;
    endtask

    // called at a falling edge; returns at the next falling edge with inputs idle
    task automatic step(input logic [5:0] q, input logic [W-1:0] t);
        drive(q, t);
        @(negedge clk);
        drive(Q_NONE, '0);
    endtask

    task automatic check(input string tag, input logic [W-1:0] ep,
                         input logic eo, input logic eu);
        n_chk++;
        if (pc_o !== ep || ovf_o !== eo || unf_o !== eu) begin
            n_bad++;
            $display("FAIL %s: pc=%h ovf=%b unf=%b expected pc=%h ovf=%b unf=%b",
                     tag, pc_o, ovf_o, unf_o, ep, eo, eu);
        end
    endtask

    task automatic do_reset(input logic [5:0] q);
        rst = 1'b1;
        drive(q, 21'h0ABCDE);
        @(negedge clk);
        rst = 1'b0;
        drive(Q_NONE, '0);
    endtask

    initial begin
        @(negedge clk);
        do_reset(Q_NONE);
        check("R1 reset state", 21'h0, 1'b0, 1'b0);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].req, VECS[i].tgt);
            check($sformatf("R2-R8 vector %0d", i), VECS[i].exp, 1'b0, 1'b0);
        end

        // R10: pop on empty stack
        step(Q_RET, '0);
        check("R10 underflow pop", 21'h0, 1'b0, 1'b1);
        step(Q_ADV, '0);
        check("R10 underflow sticky", 21'h2, 1'b0, 1'b1);

        // R1: reset wins over a simultaneous call, and no entry is saved
        do_reset(Q_CALL);
        check("R1 reset over call", 21'h0, 1'b0, 1'b0);
        step(Q_RET, '0);
        check("R1 no push during reset", 21'h0, 1'b0, 1'b1);
        do_reset(Q_NONE);
        check("R1 flags cleared", 21'h0, 1'b0, 1'b0);

        // R5 R9: fill 31 entries, then one more push
        for (int k = 0; k < 31; k++) begin
            step(Q_CALL, W'((k + 1) * 32'h400));
        end
        check("R5 deep call", W'(31 * 32'h400), 1'b0, 1'b0);
        step(Q_CALL, 21'h0ABCDE);
        check("R9 overflow push", 21'h0ABCDE, 1'b1, 1'b0);
        step(Q_HI, '0);
        check("R9 vector on full stack", 21'h000008, 1'b1, 1'b0);
        for (int k = 30; k >= 0; k--) begin
            step(Q_RET, '0);
            check($sformatf("R5 R9 unwind %0d", k),
                  (k == 0) ? W'(2) : W'(k * 32'h400 + 2), 1'b1, 1'b0);
        end
        step(Q_RET, '0);
        check("R10 underflow after unwind", 21'h0, 1'b1, 1'b1);

        do_reset(Q_NONE);
        check("R1 final reset", 21'h0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule